// File: doc/BRIEF.md
# Multidrop Receiver Sleep and Wake Controller

This block sits next to a serial receiver on a shared multidrop line. Software sets a sleep control bit to tell the receiver to ignore traffic that is not meant for this node. While the bit is set, the block raises a flag-inhibit output. The receiver uses that output to hold back its status flags and interrupts. The block clears the bit in hardware when the chosen wake condition appears.

Two wake conditions exist, and a select input picks one of them. The first is an idle string: a run of consecutive one bits as long as a whole frame, which is 10 bit times for short frames and 11 for long frames. The second is an address mark: a completed word whose most significant data bit is one. The word that carries the mark is passed through with flags enabled, so software can compare the address. Software can then put the node back to sleep until the next mark.

Top module: `mp_wake_ctrl`

## Requirements
- R1: After reset, `asleep_o` and `flag_inhibit_o` are both 0.
- R2: A cycle with `sw_wr_i`=1 loads `sw_sleep_i` into the sleep bit, and `asleep_o` shows the new value after the next rising clock edge.
- R3: While awake, `flag_inhibit_o` is 0. While asleep, it is 1, except in the address-mark cycle described in R8.
- R4: In idle mode (`wake_sel_i`=0) with `long_frame_i`=0, the 10th consecutive bit strobe carrying a one clears the sleep bit at the clock edge that ends that strobe cycle. Nine ones do not clear it.
- R5: In idle mode with `long_frame_i`=1, 11 consecutive ones are needed. Ten ones do not wake the node.
- R6: In idle mode, a bit strobe carrying a zero restarts the count of consecutive ones.
- R7: The count of consecutive ones starts from zero when sleep is entered. Ones received while awake, or in the cycle that sets the sleep bit, do not count.
- R8: In address-mark mode (`wake_sel_i`=1), a `frame_done_i` cycle whose word MSB is 1 clears the sleep bit at the next edge, and `flag_inhibit_o` is 0 during that cycle. The MSB is `rx_word_i[7]` when `long_frame_i`=0 and `rx_word_i[8]` when `long_frame_i`=1.
- R9: In address-mark mode, a completed word whose MSB is 0 does not wake the node, and neither does any run of ones on the line.
- R10: In idle mode, completed words do not wake the node, whatever their MSB.
- R11: If a software write that sets the sleep bit lands in the same cycle as a wake event, the bit stays set. In idle mode the ones count then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe for each received bit time |
| line_bit_i | input | 1 | Line value that goes with `bit_stb_i` |
| frame_done_i | input | 1 | One-cycle strobe when a word is complete |
| rx_word_i | input | 9 | Received word; bit 8 is valid only for long frames |
| long_frame_i | input | 1 | Frame length: 0 for 8 data bits, 1 for 9 data bits |
| wake_sel_i | input | 1 | Wake method: 0 for idle string, 1 for address mark |
| sw_wr_i | input | 1 | Software write strobe for the sleep bit |
| sw_sleep_i | input | 1 | Value that software writes into the sleep bit |
| flag_inhibit_o | output | 1 | Holds back receiver flags and interrupts |
| asleep_o | output | 1 | Current value of the sleep bit |

## Verification
A hardware wake event and a software write to the sleep bit can fall in the same cycle. The bench provokes this twice. In idle mode, it drives the strobe carrying the final one of an idle string together with a write that sets the bit. In address-mark mode, it drives a marked word together with the same write. In both cases the bit must stay set. In the address case, the inhibit must still drop for the marked word. In the idle case, a further nine ones must leave the node asleep and a tenth must wake it, which shows that the count restarted.

// File: rtl/mp_wake_pkg.sv
package mp_wake_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_method_e;

  // ones in a full frame: start + data + stop (+1 data bit for long frames)
  function automatic int unsigned frame_bits(int unsigned data_bits, logic long_frame);
    return data_bits + 2 + (long_frame ? 1 : 0);
  endfunction
endpackage

// File: rtl/mp_idle_run_cnt.sv
module mp_idle_run_cnt #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned MAX_RUN = DATA_BITS + 3,
  localparam int unsigned CNT_W = $clog2(MAX_RUN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  input  logic bit_i,
  input  logic long_i,
  output logic hit_o
);
  import mp_wake_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d, last_one;

  assign last_one = CNT_W'(frame_bits(DATA_BITS, long_i) - 1);
  assign hit_o    = ~clr_i & stb_i & bit_i & (cnt_q >= last_one);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || hit_o) cnt_d = '0;
    else if (stb_i)     cnt_d = bit_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R6: a zero strobe leaves the count at zero
  a_r6_zero_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !bit_i) |=> (cnt_q == '0));
  // R7: the count stays at zero while cleared
  a_r7_clear_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r4_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_RUN));
endmodule

// File: rtl/mp_mark_detect.sv
module mp_mark_detect #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned WORD_W = DATA_BITS + 1
) (
  input  logic              en_i,
  input  logic              frame_done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              long_i,
  output logic              mark_o
);
  logic msb;
  assign msb    = long_i ? word_i[DATA_BITS] : word_i[DATA_BITS-1];
  assign mark_o = en_i & frame_done_i & msb;
endmodule

// File: rtl/mp_sleep_reg.sv
module mp_sleep_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_wr_i,
  input  logic sw_val_i,
  input  logic wake_i,
  output logic asleep_o
);
  logic asleep_q;

  // a software write wins over a hardware wake in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      asleep_q <= 1'b0;
    else if (sw_wr_i) asleep_q <= sw_val_i;
    else if (wake_i)  asleep_q <= 1'b0;
  end

  assign asleep_o = asleep_q;

  a_r2_sw_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr_i |=> (asleep_o == $past(sw_val_i)));
  a_r4_wake_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !sw_wr_i) |=> !asleep_o);
  a_r11_sw_beats_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && sw_wr_i && sw_val_i) |=> asleep_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_i && !sw_wr_i) |=> $stable(asleep_o));
endmodule

// File: rtl/mp_wake_ctrl.sv
module mp_wake_ctrl #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned WORD_W = DATA_BITS + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              line_bit_i,
  input  logic              frame_done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              long_frame_i,
  input  logic              wake_sel_i,
  input  logic              sw_wr_i,
  input  logic              sw_sleep_i,
  output logic              flag_inhibit_o,
  output logic              asleep_o
);
  import mp_wake_pkg::*;

  wake_method_e method;
  logic asleep, idle_hit, mark_hit, wake, idle_clr;

  assign method   = wake_method_e'(wake_sel_i);
  assign idle_clr = ~asleep | (method != WAKE_IDLE);

  mp_idle_run_cnt #(.DATA_BITS(DATA_BITS)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (idle_clr),
    .stb_i  (bit_stb_i),
    .bit_i  (line_bit_i),
    .long_i (long_frame_i),
    .hit_o  (idle_hit)
  );

  mp_mark_detect #(.DATA_BITS(DATA_BITS)) u_mark (
    .en_i         (asleep && method == WAKE_ADDR),
    .frame_done_i (frame_done_i),
    .word_i       (rx_word_i),
    .long_i       (long_frame_i),
    .mark_o       (mark_hit)
  );

  assign wake = idle_hit | mark_hit;

  mp_sleep_reg u_sleep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_wr_i  (sw_wr_i),
    .sw_val_i (sw_sleep_i),
    .wake_i   (wake),
    .asleep_o (asleep)
  );

  // the marked word itself passes with flags enabled
  assign flag_inhibit_o = asleep & ~mark_hit;
  assign asleep_o       = asleep;

  a_r3_awake_no_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !asleep_o |-> !flag_inhibit_o);
  a_r8_mark_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && wake_sel_i && frame_done_i &&
     (long_frame_i ? rx_word_i[DATA_BITS] : rx_word_i[DATA_BITS-1])) |-> !flag_inhibit_o);
  a_r10_idle_ignores_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && !wake_sel_i && !bit_stb_i && !sw_wr_i) |=> asleep_o);
  a_r9_addr_ignores_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && wake_sel_i && !frame_done_i && !sw_wr_i) |=> asleep_o);
endmodule

// File: tb/mp_wake_ctrl_test.sv
module mp_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bit_stb = 0, line_bit = 1, frame_done = 0, long_frame = 0;
  logic wake_sel = 0, sw_wr = 0, sw_sleep = 0;
  logic [8:0] rx_word = '0;
  logic inhibit, asleep;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_wake_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(bit_stb), .line_bit_i(line_bit),
    .frame_done_i(frame_done), .rx_word_i(rx_word), .long_frame_i(long_frame),
    .wake_sel_i(wake_sel), .sw_wr_i(sw_wr), .sw_sleep_i(sw_sleep),
    .flag_inhibit_o(inhibit), .asleep_o(asleep)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic go_sleep();
    @(negedge clk); sw_wr = 1; sw_sleep = 1;
    @(negedge clk); sw_wr = 0;
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); bit_stb = 1; line_bit = b;
    @(negedge clk); bit_stb = 0; line_bit = 1;
  endtask

  task automatic send_ones(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_word(logic [8:0] w, string req, logic exp_inh);
    @(negedge clk); frame_done = 1; rx_word = w;
    #1 chk(req, inhibit, exp_inh);
    @(negedge clk); frame_done = 0;
  endtask

  // {wake_sel, long_frame, ones[4:0], expected asleep}
  localparam logic [7:0] VEC [8] = '{
    {1'b0, 1'b0, 5'd9,  1'b1},   // R4
    {1'b0, 1'b0, 5'd10, 1'b0},   // R4
    {1'b0, 1'b1, 5'd10, 1'b1},   // R5
    {1'b0, 1'b1, 5'd11, 1'b0},   // R5
    {1'b0, 1'b0, 5'd15, 1'b0},   // R4
    {1'b1, 1'b0, 5'd20, 1'b1},   // R9
    {1'b1, 1'b1, 5'd12, 1'b1},   // R9
    {1'b0, 1'b1, 5'd1,  1'b1}    // R5
  };

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 asleep", asleep, 1'b0);
    chk("R1 inhibit", inhibit, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", asleep, 1'b0);

    // R2 / R3 software write and inhibit
    @(negedge clk); sw_wr = 1; sw_sleep = 1;
    #1 chk("R2 not before edge", asleep, 1'b0);
    @(negedge clk); sw_wr = 0;
    chk("R2 set", asleep, 1'b1);
    chk("R3 inhibit asleep", inhibit, 1'b1);
    @(negedge clk); sw_wr = 1; sw_sleep = 0;
    @(negedge clk); sw_wr = 0;
    chk("R2 clear", asleep, 1'b0);
    chk("R3 inhibit awake", inhibit, 1'b0);

    // table walk: R4 R5 R9
    foreach (VEC[i]) begin
      wake_sel = VEC[i][7]; long_frame = VEC[i][6];
      go_sleep();
      send_ones(int'(VEC[i][5:1]));
      chk($sformatf("R4/R5/R9 vec%0d", i), asleep, VEC[i][0]);
      @(negedge clk); sw_wr = 1; sw_sleep = 0;
      @(negedge clk); sw_wr = 0;
    end

    // R6 zero restarts the run
    wake_sel = 0; long_frame = 0;
    go_sleep();
    send_ones(9); send_bit(1'b0); send_ones(9);
    chk("R6 zero restarts", asleep, 1'b1);
    send_bit(1'b1);
    chk("R6 wakes after fresh run", asleep, 1'b0);

    // R7 ones before sleep do not count
    send_ones(8);
    @(negedge clk); sw_wr = 1; sw_sleep = 1; bit_stb = 1; line_bit = 1;
    @(negedge clk); sw_wr = 0; bit_stb = 0;
    send_ones(9);
    chk("R7 pre-sleep ones ignored", asleep, 1'b1);
    send_bit(1'b1);
    chk("R7 wake after full run", asleep, 1'b0);

    // R10 idle mode ignores words
    go_sleep();
    send_word(9'h080, "R10 inhibit kept", 1'b1);
    chk("R10 still asleep", asleep, 1'b1);

    // R8 / R9 address mark
    @(negedge clk); sw_wr = 1; sw_sleep = 0;
    @(negedge clk); sw_wr = 0;
    wake_sel = 1; long_frame = 0;
    go_sleep();
    send_word(9'h07F, "R9 unmarked inhibited", 1'b1);
    chk("R9 unmarked no wake", asleep, 1'b1);
    send_word(9'h100, "R8 bit8 ignored short", 1'b1);
    chk("R8 bit8 ignored short", asleep, 1'b1);
    send_word(9'h0A5, "R8 mark passes", 1'b0);
    chk("R8 woken", asleep, 1'b0);
    long_frame = 1;
    go_sleep();
    send_word(9'h080, "R8 bit7 ignored long", 1'b1);
    chk("R8 bit7 ignored long", asleep, 1'b1);
    send_word(9'h100, "R8 long mark passes", 1'b0);
    chk("R8 long woken", asleep, 1'b0);

    // R11 collision: address mark with sleep write
    go_sleep();
    @(negedge clk); frame_done = 1; rx_word = 9'h100; sw_wr = 1; sw_sleep = 1;
    #1 chk("R11 mark inhibit low", inhibit, 1'b0);
    @(negedge clk); frame_done = 0; sw_wr = 0;
    chk("R11 addr stays asleep", asleep, 1'b1);

    // R11 collision: idle hit with sleep write, run restarts
    wake_sel = 0; long_frame = 0;
    send_ones(9);
    @(negedge clk); bit_stb = 1; line_bit = 1; sw_wr = 1; sw_sleep = 1;
    @(negedge clk); bit_stb = 0; sw_wr = 0;
    chk("R11 idle stays asleep", asleep, 1'b1);
    send_ones(9);
    chk("R11 run restarted", asleep, 1'b1);
    send_bit(1'b1);
    chk("R11 wake after restart", asleep, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule